// File: doc/BRIEF.md
# UART Error Interrupt Aggregator

This block gathers the receive-side error events of a UART (break, parity error, framing error and overrun) and reduces them to a single maskable interrupt request. Each event reaches it as a one-cycle pulse in the UART clock domain. The block holds a request flag for each source and gates that flag with an enable bit. It then ORs the gated results into one registered interrupt line.

The sources are cleared in two ways. The break, parity and framing flags stay set until software writes a one to their bit in a clear register. The overrun indication does not respond to that register. It follows the overrun condition and goes away when the receive FIFO is read, which a read strobe signals. A small write port reaches the enable mask and the clear register. A combinational read port returns the mask, the raw flags or the masked flags. Bit order in all registers: bit 3 overrun, bit 2 break, bit 1 parity, bit 0 framing.

Top module: `uart_err_irq`

## Requirements
- R1: After a synchronous reset with `rstN` low, the raw flags, masked flags, enable mask and `irqOut` are all zero.
- R2: A pulse on `brkEvt`, `parEvt` or `frmEvt` sets raw bit 2, 1 or 0 respectively on the next clock edge, and the bit stays set with no further pulses.
- R3: A write to address 1 (clear register) clears each of raw bits 2..0 written as 1. Bits written as 0 are unchanged. Reading address 1 returns 0.
- R4: If an event pulse and a clear write of the same sticky bit occur in the same cycle, the bit ends up set.
- R5: Raw bit 3 (overrun) is set by an `ovrEvt` pulse and cleared by a `fifoRdStb` pulse. A write to the clear register does not change it.
- R6: If `ovrEvt` and `fifoRdStb` occur in the same cycle, raw bit 3 ends up set.
- R7: `maskedFlags` equals the raw flags ANDed with the enable mask. Reading address 2 returns the raw flags and address 3 returns the masked flags.
- R8: `irqOut` is the OR of the masked flags, delayed by one clock edge.
- R9: A write to address 0 replaces the enable mask, which reads back at address 0. Writes to addresses 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rstN | input | 1 | Active-low synchronous reset |
| brkEvt | input | 1 | Break detected pulse |
| parEvt | input | 1 | Parity error pulse |
| frmEvt | input | 1 | Framing error pulse |
| ovrEvt | input | 1 | Overrun pulse |
| fifoRdStb | input | 1 | Receive FIFO read strobe |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 4 | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | 4 | Register read data (combinational) |
| rawFlags | output | 4 | Flags before masking |
| maskedFlags | output | 4 | Flags after masking |
| irqOut | output | 1 | Combined interrupt request, registered |

## Verification
The bench aims at collisions. It pulses an event in the same cycle that a clear write targets that bit, and a design where the clear wins would lose the event and read zero. It raises an overrun together with a FIFO read, and it writes the clear register while an overrun is pending. A design that routes the clear register to bit 3 would drop the overrun flag. The bench also samples `irqOut` in the cycle the masked status first changes and again one cycle later. A combinational output, or one with an extra stage, fails one of those two samples. Zero bits in the clear value are checked so that a plain write, rather than a write-one-to-clear, is caught.

// File: rtl/uart_err_pkg.sv
package uart_err_pkg;
  localparam int NUM_SRC = 4;
  localparam int IDX_OVR = 3;
  localparam int IDX_BRK = 2;
  localparam int IDX_PAR = 1;
  localparam int IDX_FRM = 0;
  localparam int NUM_STICKY = 3;

  localparam int ADDR_MASK  = 0;
  localparam int ADDR_CLR   = 1;
  localparam int ADDR_RAW   = 2;
  localparam int ADDR_MSKD  = 3;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  typedef struct packed {
    logic    maskWr;
    srcVec_t maskVal;
    srcVec_t clrHit;
  } ctrlStrobes_t;
endpackage

// File: rtl/uart_err_ctrl.sv
module uart_err_ctrl
  import uart_err_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  srcVec_t           wrData,
  output ctrlStrobes_t      strb
);
  logic hitMask;
  logic hitClr;

  always_comb begin
    hitMask = wrEn && (wrAddr == ADDR_W'(ADDR_MASK));
    hitClr  = wrEn && (wrAddr == ADDR_W'(ADDR_CLR));
    strb.maskWr  = hitMask;
    strb.maskVal = wrData;
    strb.clrHit  = hitClr ? wrData : '0;
  end
endmodule

// File: rtl/uart_err_dp.sv
module uart_err_dp
  import uart_err_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcVec_t           setVec,
  input  logic              fifoRd,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output srcVec_t           rdData,
  output srcVec_t           rawFlags,
  output srcVec_t           maskedFlags,
  output logic              irqOut
);
  srcVec_t maskQ;
  srcVec_t flagQ;
  logic    irqQ;

  // Sticky sources: set by event, cleared by write-one-to-clear, set wins
  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)              flagQ[i] <= 1'b0;
      else if (setVec[i])     flagQ[i] <= 1'b1;
      else if (strb.clrHit[i]) flagQ[i] <= 1'b0;
    end

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrHit[i] && !setVec[i]) |=> !rawFlags[i]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      setVec[i] |=> rawFlags[i]);
  end

  // Overrun condition: tracks overrun until the FIFO is read; clear register ignored
  always_ff @(posedge clk) begin
    if (!rstN)                 flagQ[IDX_OVR] <= 1'b0;
    else if (setVec[IDX_OVR])  flagQ[IDX_OVR] <= 1'b1;
    else if (fifoRd)           flagQ[IDX_OVR] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strb.maskWr) maskQ <= strb.maskVal;
  end

  always_comb begin
    rawFlags    = flagQ;
    maskedFlags = flagQ & maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |maskedFlags;
  end
  assign irqOut = irqQ;

  always_comb begin
    unique case (int'(rdAddr))
      ADDR_MASK: rdData = maskQ;
      ADDR_RAW:  rdData = flagQ;
      ADDR_MSKD: rdData = maskedFlags;
      default:   rdData = '0;
    endcase
  end

  // R5
  ovr_read_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRd && !setVec[IDX_OVR]) |=> !rawFlags[IDX_OVR]);
  // R5
  ovr_ignores_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrHit[IDX_OVR] && !fifoRd && rawFlags[IDX_OVR]) |=> rawFlags[IDX_OVR]);
  // R6
  ovr_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    setVec[IDX_OVR] |=> rawFlags[IDX_OVR]);
  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskedFlags & ~maskQ) == '0);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|maskedFlags) |=> irqOut);
  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskedFlags == '0) |=> !irqOut);
endmodule

// File: rtl/uart_err_irq.sv
module uart_err_irq
  import uart_err_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brkEvt,
  input  logic              parEvt,
  input  logic              frmEvt,
  input  logic              ovrEvt,
  input  logic              fifoRdStb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [3:0]        rdData,
  output logic [3:0]        rawFlags,
  output logic [3:0]        maskedFlags,
  output logic              irqOut
);
  ctrlStrobes_t strb;
  srcVec_t      setVec;

  always_comb begin
    setVec          = '0;
    setVec[IDX_OVR] = ovrEvt;
    setVec[IDX_BRK] = brkEvt;
    setVec[IDX_PAR] = parEvt;
    setVec[IDX_FRM] = frmEvt;
  end

  uart_err_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb)
  );

  uart_err_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .setVec      (setVec),
    .fifoRd      (fifoRdStb),
    .strb        (strb),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .rawFlags    (rawFlags),
    .maskedFlags (maskedFlags),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/uart_err_irq_bench.sv
`timescale 1ns/1ps
module uart_err_irq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       brkEvt = 0, parEvt = 0, frmEvt = 0, ovrEvt = 0, fifoRdStb = 0;
  logic       wrEn = 0;
  logic [1:0] wrAddr = '0;
  logic [3:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [3:0] rdData, rawFlags, maskedFlags;
  logic       irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_err_irq u_uart_err_irq (
    .clk(clk), .rstN(rstN), .brkEvt(brkEvt), .parEvt(parEvt), .frmEvt(frmEvt),
    .ovrEvt(ovrEvt), .fifoRdStb(fifoRdStb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .rawFlags(rawFlags),
    .maskedFlags(maskedFlags), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // evt bits: 3 overrun, 2 break, 1 parity, 0 framing. Called at a negedge.
  task automatic step(input logic [3:0] evt, input logic rd, input logic we,
                      input logic [1:0] addr, input logic [3:0] data);
    ovrEvt = evt[3]; brkEvt = evt[2]; parEvt = evt[1]; frmEvt = evt[0];
    fifoRdStb = rd; wrEn = we; wrAddr = addr; wrData = data;
    @(negedge clk);
    {ovrEvt, brkEvt, parEvt, frmEvt} = '0;
    fifoRdStb = 0; wrEn = 0;
  endtask

  task automatic idle(); step(4'h0, 0, 0, 2'd0, 4'h0); endtask

  task automatic testReset();
    check("R1 raw", rawFlags, 4'h0);
    check("R1 masked", maskedFlags, 4'h0);
    rdAddr = 2'd0; #1;
    check("R1 mask", rdData, 4'h0);
    check("R1 irq", {3'b0, irqOut}, 4'h0);
  endtask

  task automatic testSticky();
    step(4'b0100, 0, 0, 0, 0);
    check("R2 break set", rawFlags, 4'h4);
    idle(); idle();
    check("R2 break held", rawFlags, 4'h4);
    step(4'b0010, 0, 0, 0, 0);
    step(4'b0001, 0, 0, 0, 0);
    check("R2 parity framing set", rawFlags, 4'h7);
  endtask

  task automatic testClear();
    step(4'h0, 0, 1, 2'd1, 4'h0);
    check("R3 zero write no effect", rawFlags, 4'h7);
    rdAddr = 2'd1; #1;
    check("R3 clear reads zero", rdData, 4'h0);
    step(4'h0, 0, 1, 2'd1, 4'b0010);
    check("R3 clear parity only", rawFlags, 4'h5);
    step(4'h0, 0, 1, 2'd1, 4'b0101);
    check("R3 clear rest", rawFlags, 4'h0);
  endtask

  task automatic testSetWins();
    step(4'b0001, 0, 1, 2'd1, 4'b0001);
    check("R4 set beats clear", rawFlags, 4'h1);
    step(4'h0, 0, 1, 2'd1, 4'b0001);
    check("R4 later clear", rawFlags, 4'h0);
  endtask

  task automatic testOverrun();
    step(4'b1000, 0, 0, 0, 0);
    check("R5 overrun set", rawFlags, 4'h8);
    step(4'h0, 0, 1, 2'd1, 4'hF);
    check("R5 clear reg ignored", rawFlags, 4'h8);
    step(4'h0, 1, 0, 0, 0);
    check("R5 fifo read clears", rawFlags, 4'h0);
    step(4'b1000, 1, 0, 0, 0);
    check("R6 overrun beats read", rawFlags, 4'h8);
    step(4'h0, 1, 0, 0, 0);
    check("R6 read after", rawFlags, 4'h0);
  endtask

  task automatic testMaskIrq();
    step(4'h0, 0, 1, 2'd0, 4'b0101);
    rdAddr = 2'd0; #1;
    check("R9 mask readback", rdData, 4'h5);
    check("R8 irq idle", {3'b0, irqOut}, 4'h0);
    step(4'b0110, 0, 0, 0, 0);
    check("R7 raw", rawFlags, 4'h6);
    check("R7 masked", maskedFlags, 4'h4);
    rdAddr = 2'd2; #1;
    check("R7 raw read", rdData, 4'h6);
    rdAddr = 2'd3; #1;
    check("R7 masked read", rdData, 4'h4);
    check("R8 irq not yet", {3'b0, irqOut}, 4'h0);
    idle();
    check("R8 irq raised", {3'b0, irqOut}, 4'h1);
    step(4'h0, 0, 1, 2'd1, 4'b0100);
    check("R8 masked cleared", maskedFlags, 4'h0);
    check("R8 irq still high", {3'b0, irqOut}, 4'h1);
    idle();
    check("R8 irq dropped", {3'b0, irqOut}, 4'h0);
    step(4'h0, 0, 1, 2'd2, 4'hF);
    step(4'h0, 0, 1, 2'd3, 4'hF);
    check("R9 raw write ignored", rawFlags, 4'h2);
    rdAddr = 2'd0; #1;
    check("R9 mask unchanged", rdData, 4'h5);
    step(4'h0, 0, 1, 2'd0, 4'b0010);
    check("R9 mask replaced", maskedFlags, 4'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSticky();
    testClear();
    testSetWins();
    testOverrun();
    testMaskIrq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule